// File: doc/BRIEF.md
# Serial Flash Memory Emulator

This block is a synthesizable slave that answers a mode-0 SPI bus as a small serial flash memory would. A host selects it by pulling chip select low. The host then shifts in a one-byte command and, where the command needs one, a 24-bit byte address, most significant byte first. Depending on the command, the block streams out array data or the status byte, or it accepts data for a page program. Erase, program and status-write commands are carried out on an on-chip byte array after chip select returns high.

The SPI pins are brought into the system clock domain through a synchronizer chain. A write engine then sweeps the affected address range one byte per system clock, followed by a fixed tail of busy cycles that stands for the flash's programming time. While that engine runs, the status byte reports a write in progress, and every command except a status read is turned away.

A power-down command puts the block into a state where it only answers the release command. The release command also returns a fixed identification byte.

Top module: `spi_flash_emu`

## Requirements
- R1: Command and address bits are taken on rising SCK edges, MSB first. A read (0x03) followed by three address bytes returns array bytes starting at that address, MSB first, with MISO changing after falling SCK edges, and the address advancing by one per byte.
- R2: Only the low ADDR_W address bits select a byte. A read that passes the last array byte (2^ADDR_W-1) continues at byte 0.
- R3: MISO is 0 while chip select is high, and also during any byte in which the selected command has nothing to return.
- R4: Status read (0x05) returns {stored bits[7:2], bit1 = write-enable latch, bit0 = write in progress} for as long as select stays low. After reset it reads 0x00.
- R5: Command 0x06 sets the write-enable latch and command 0x04 clears it, each when select rises.
- R6: Page program, sector erase, bulk erase and status write are discarded when the write-enable latch is clear.
- R7: Page program (0x02, address, one or more data bytes) writes each byte at the next offset within the addressed 128-byte page. Offsets wrap from 127 to 0 of the same page. The stored result is the old byte ANDed with the sent byte.
- R8: Sector erase (0xD8, address) sets the 256-byte sector holding the address to 0xFF. Bulk erase (0xC7) sets the whole array to 0xFF.
- R9: Write in progress reads 1 from the deselect of an accepted write command until the operation finishes, and the latch is then cleared. Meanwhile every command except status read is ignored, and its output stays 0.
- R10: A write-type command whose select rises on a non-byte boundary is discarded, and the latch is left unchanged.
- R11: After 0xB9 every command except 0xAB is ignored. 0xAB releases the block and, after three further bytes, returns the byte SIG_BYTE (default 0x10) repeatedly.
- R12: Status write (0x01, data byte) stores data bits 7:2 into the status byte. Bits 1:0 are not writable.
- R13: After reset every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, driven low when idle |

## Verification
A corrupted write-enable latch or busy flag shows up at the ports in two ways: the next status read returns the wrong value, and a later read returns the wrong data after a write was wrongly accepted or lost. A wrong bit or byte counter misaligns the address, and the first data byte of the next read then comes back shifted or from the wrong location. Errors in the page-offset or sweep logic surface only when the affected bytes are read back. The bench therefore reads back the page-wrap byte, the array-wrap byte and the bytes just outside an erased sector, directly after each operation.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_PP   = 8'h02;
   localparam logic [7:0] OP_SE   = 8'hD8;
   localparam logic [7:0] OP_BE   = 8'hC7;
   localparam logic [7:0] OP_DP   = 8'hB9;
   localparam logic [7:0] OP_RES  = 8'hAB;

   typedef enum logic [1:0] {
      JOB_PROG = 2'd0,
      JOB_FILL = 2'd1,
      JOB_WAIT = 2'd2
   } job_e;
endpackage

// File: rtl/sfe_sync_edge.sv
`timescale 1ns/1ps
module sfe_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sck_i,
   input  logic mosi_i,
   output logic cs_act_o,
   output logic cs_fall_o,
   output logic cs_rise_o,
   output logic sck_rise_o,
   output logic sck_fall_o,
   output logic mosi_o
);
   // stage bit order: {cs_n, sck, mosi}
   logic [2:0] stg [SYNC_STAGES];
   logic       cs_q, sck_q;
   logic       cs_cur, sck_cur;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= 3'b100;
               else        stg[0] <= {cs_n_i, sck_i, mosi_i};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= 3'b100;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign cs_cur = stg[SYNC_STAGES-1][2];
   assign sck_cur = stg[SYNC_STAGES-1][1];
   assign mosi_o = stg[SYNC_STAGES-1][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_cur;
         sck_q <= sck_cur;
      end
   end

   assign cs_act_o   = ~cs_cur;
   assign cs_fall_o  = cs_q & ~cs_cur;
   assign cs_rise_o  = ~cs_q & cs_cur;
   assign sck_rise_o = ~cs_cur & sck_cur & ~sck_q;
   assign sck_fall_o = ~cs_cur & ~sck_cur & sck_q;
endmodule

// File: rtl/sfe_array.sv
`timescale 1ns/1ps
module sfe_array
   import sfe_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int PAGE_W   = 7,
   parameter int TAIL_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   input  logic              buf_clr_i,
   input  logic              buf_we_i,
   input  logic [PAGE_W-1:0] buf_idx_i,
   input  logic [7:0]        buf_data_i,
   input  logic              start_i,
   input  job_e              job_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W:0]   len_i,
   output logic              busy_o,
   output logic              done_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PAGE  = 1 << PAGE_W;
   localparam int CW    = $clog2(DEPTH + TAIL_CYC + 1) + 1;

   logic [7:0]        mem  [DEPTH];
   logic [7:0]        pbuf [PAGE];
   logic [PAGE-1:0]   pmask;
   job_e              job_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W:0]   len_q;
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     last_c;
   logic              sweep_on;
   logic [ADDR_W-1:0] tgt;
   logic [PAGE_W-1:0] off;

   assign last_c    = CW'(len_q) + CW'(TAIL_CYC) - CW'(1);
   assign sweep_on  = busy_o && (cnt < CW'(len_q));
   assign tgt       = base_q + cnt[ADDR_W-1:0];
   assign off       = cnt[PAGE_W-1:0];
   assign rd_data_o = mem[rd_addr_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         cnt    <= '0;
         job_q  <= JOB_WAIT;
         base_q <= '0;
         len_q  <= '0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            busy_o <= 1'b1;
            cnt    <= '0;
            job_q  <= job_i;
            base_q <= base_i;
            len_q  <= len_i;
         end else if (busy_o) begin
            if (cnt == last_c) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (sweep_on) begin
         if (job_q == JOB_PROG) begin
            if (pmask[off]) mem[tgt] <= mem[tgt] & pbuf[off];
         end else if (job_q == JOB_FILL) begin
            mem[tgt] <= 8'hFF;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pmask <= '0;
      end else if (buf_clr_i) begin
         pmask <= '0;
      end else if (buf_we_i) begin
         pmask[buf_idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (buf_we_i) pbuf[buf_idx_i] <= buf_data_i;
   end

   // R9: a new job never lands on a running one
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !start_i);
   // R9: an accepted job raises the in-progress flag at once
   a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);
endmodule

// File: rtl/sfe_cmd.sv
`timescale 1ns/1ps
module sfe_cmd
   import sfe_pkg::*;
#(
   parameter int         ADDR_W   = 10,
   parameter int         PAGE_W   = 7,
   parameter int         SECTOR_W = 8,
   parameter logic [7:0] SIG_BYTE = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act_i,
   input  logic              cs_fall_i,
   input  logic              cs_rise_i,
   input  logic              sck_rise_i,
   input  logic              sck_fall_i,
   input  logic              mosi_i,
   input  logic [7:0]        rd_data_i,
   input  logic              busy_i,
   input  logic              done_i,
   output logic              miso_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              buf_clr_o,
   output logic              buf_we_o,
   output logic [PAGE_W-1:0] buf_idx_o,
   output logic [7:0]        buf_data_o,
   output logic              start_o,
   output job_e              job_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W:0]   len_o
);
   localparam int LEN_W  = ADDR_W + 1;
   localparam int PAGE   = 1 << PAGE_W;
   localparam int SECTOR = 1 << SECTOR_W;
   localparam int DEPTH  = 1 << ADDR_W;

   logic [2:0]        bit_cnt;
   logic [2:0]        byte_cnt;
   logic [6:0]        shreg;
   logic [7:0]        op;
   logic              op_ok;
   logic [23:0]       addr;
   logic [ADDR_W-1:0] ptr;
   logic [7:0]        tx;
   logic              tx_on;
   logic              wel;
   logic              pd;
   logic [5:0]        sr_hi;
   logic [7:0]        wr_val;
   logic [PAGE_W-1:0] poff;

   logic [7:0]  rx_byte;
   logic [23:0] addr_nx;
   logic [7:0]  status;
   logic        accept;

   assign rx_byte   = {shreg, mosi_i};
   assign addr_nx   = {addr[15:0], rx_byte};
   assign status    = {sr_hi, wel, busy_i};
   assign rd_addr_o = (byte_cnt == 3'd3) ? addr_nx[ADDR_W-1:0] : ptr;

   always_comb begin
      if (pd)          accept = (rx_byte == OP_RES);
      else if (busy_i) accept = (rx_byte == OP_RDSR);
      else             accept = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         byte_cnt   <= '0;
         shreg      <= '0;
         op         <= '0;
         op_ok      <= 1'b0;
         addr       <= '0;
         ptr        <= '0;
         tx         <= '0;
         tx_on      <= 1'b0;
         miso_o     <= 1'b0;
         wel        <= 1'b0;
         pd         <= 1'b0;
         sr_hi      <= '0;
         wr_val     <= '0;
         poff       <= '0;
         buf_clr_o  <= 1'b0;
         buf_we_o   <= 1'b0;
         buf_idx_o  <= '0;
         buf_data_o <= '0;
         start_o    <= 1'b0;
         job_o      <= JOB_WAIT;
         base_o     <= '0;
         len_o      <= '0;
      end else begin
         start_o   <= 1'b0;
         buf_clr_o <= 1'b0;
         buf_we_o  <= 1'b0;
         if (done_i) wel <= 1'b0;

         if (cs_fall_i) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            op_ok    <= 1'b0;
            tx_on    <= 1'b0;
            miso_o   <= 1'b0;
         end else if (cs_rise_i) begin
            miso_o <= 1'b0;
            tx_on  <= 1'b0;
            if (bit_cnt == 3'd0 && op_ok) begin
               case (op)
                  OP_WREN: wel <= 1'b1;
                  OP_WRDI: wel <= 1'b0;
                  OP_DP:   pd  <= 1'b1;
                  OP_PP: if (wel && byte_cnt == 3'd5) begin
                     start_o <= 1'b1;
                     job_o   <= JOB_PROG;
                     base_o  <= addr[ADDR_W-1:0] & ~ADDR_W'(PAGE - 1);
                     len_o   <= LEN_W'(PAGE);
                  end
                  OP_SE: if (wel && byte_cnt >= 3'd4) begin
                     start_o <= 1'b1;
                     job_o   <= JOB_FILL;
                     base_o  <= addr[ADDR_W-1:0] & ~ADDR_W'(SECTOR - 1);
                     len_o   <= LEN_W'(SECTOR);
                  end
                  OP_BE: if (wel) begin
                     start_o <= 1'b1;
                     job_o   <= JOB_FILL;
                     base_o  <= '0;
                     len_o   <= LEN_W'(DEPTH);
                  end
                  OP_WRSR: if (wel && byte_cnt >= 3'd2) begin
                     sr_hi   <= wr_val[7:2];
                     start_o <= 1'b1;
                     job_o   <= JOB_WAIT;
                     base_o  <= '0;
                     len_o   <= '0;
                  end
                  default: ;
               endcase
            end
         end else if (cs_act_i) begin
            if (sck_fall_i) miso_o <= tx_on & tx[3'd7 - bit_cnt];
            if (sck_rise_i) begin
               shreg   <= rx_byte[6:0];
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  if (byte_cnt != 3'd5) byte_cnt <= byte_cnt + 3'd1;
                  if (byte_cnt == 3'd0) begin
                     op    <= rx_byte;
                     op_ok <= accept;
                     if (accept && rx_byte == OP_RDSR) begin
                        tx    <= status;
                        tx_on <= 1'b1;
                     end
                     if (accept && rx_byte == OP_RES) pd <= 1'b0;
                  end else if (op_ok) begin
                     if (byte_cnt <= 3'd3) addr <= addr_nx;
                     case (op)
                        OP_RDSR: tx <= status;
                        OP_WRSR: if (byte_cnt == 3'd1) wr_val <= rx_byte;
                        OP_READ: if (byte_cnt >= 3'd3) begin
                           tx    <= rd_data_i;
                           ptr   <= rd_addr_o + ADDR_W'(1);
                           tx_on <= 1'b1;
                        end
                        OP_PP: if (byte_cnt == 3'd3) begin
                           buf_clr_o <= 1'b1;
                           poff      <= rx_byte[PAGE_W-1:0];
                        end else if (byte_cnt >= 3'd4) begin
                           buf_we_o   <= 1'b1;
                           buf_idx_o  <= poff;
                           buf_data_o <= rx_byte;
                           poff       <= poff + PAGE_W'(1);
                        end
                        OP_RES: if (byte_cnt >= 3'd3) begin
                           tx    <= SIG_BYTE;
                           tx_on <= 1'b1;
                        end
                        default: ;
                     endcase
                  end
               end
            end
         end
      end
   end

   // R3: output returns low once select is released
   a_r3_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act_i |=> !miso_o);
   // R6: the write engine is only launched with the latch set
   a_r6_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> wel);
   // R9: latch clears when the engine reports completion
   a_r9_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !wel);
   // R11: while powered down nothing but the release byte is served
   a_r11_pd_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      (pd && cs_act_i) |=> !miso_o);
endmodule

// File: rtl/spi_flash_emu.sv
`timescale 1ns/1ps
module spi_flash_emu
   import sfe_pkg::*;
#(
   parameter int         ADDR_W      = 10,
   parameter int         PAGE_W      = 7,
   parameter int         SECTOR_W    = 8,
   parameter int         BUSY_TAIL   = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] SIG_BYTE    = 8'h10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso
);
   generate
      if (PAGE_W < 1 || PAGE_W >= SECTOR_W || SECTOR_W >= ADDR_W || ADDR_W > 24) begin : g_bad_geom
         $error("spi_flash_emu: need 1 <= PAGE_W < SECTOR_W < ADDR_W <= 24");
      end
      if (BUSY_TAIL < 1) begin : g_bad_tail
         $error("spi_flash_emu: BUSY_TAIL must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_flash_emu: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              cs_act, cs_fall, cs_rise, sck_rise, sck_fall, mosi_s;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;
   logic              buf_clr, buf_we;
   logic [PAGE_W-1:0] buf_idx;
   logic [7:0]        buf_data;
   logic              start, busy, done;
   job_e              job;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W:0]   len;

   sfe_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
      .cs_act_o(cs_act), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
      .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .mosi_o(mosi_s)
   );

   sfe_cmd #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W), .SIG_BYTE(SIG_BYTE)
   ) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .cs_act_i(cs_act), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
      .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .mosi_i(mosi_s),
      .rd_data_i(rd_data), .busy_i(busy), .done_i(done),
      .miso_o(spi_miso), .rd_addr_o(rd_addr),
      .buf_clr_o(buf_clr), .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data),
      .start_o(start), .job_o(job), .base_o(base), .len_o(len)
   );

   sfe_array #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TAIL_CYC(BUSY_TAIL)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .buf_clr_i(buf_clr), .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_data_i(buf_data),
      .start_i(start), .job_i(job), .base_i(base), .len_i(len),
      .busy_o(busy), .done_o(done)
   );
endmodule

// File: tb/spi_flash_emu_bench.sv
`timescale 1ns/1ps
module spi_flash_emu_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic miso;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] got_q [$];

   always #2.5 clk = ~clk;

   spi_flash_emu #(.BUSY_TAIL(600), .SIG_BYTE(8'h10)) u_spi_flash_emu (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .spi_miso(miso)
   );

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_b(input logic [7:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         waitc(8);
         rx[i] = miso;
         sck = 1'b1;
         waitc(8);
         sck = 1'b0;
      end
   endtask

   // send header bytes, then capture nrd returned bytes into the scoreboard
   task automatic xact(input logic [7:0] hdr [$], input int nrd);
      logic [7:0] r;
      cs_n = 1'b0;
      waitc(8);
      foreach (hdr[i]) xfer(hdr[i], r);
      for (int k = 0; k < nrd; k++) begin
         xfer(8'h00, r);
         got_q.push_back(r);
      end
      waitc(8);
      cs_n = 1'b1;
      waitc(16);
   endtask

   task automatic xact_partial(input logic [7:0] hdr [$], input int nbits);
      logic [7:0] r;
      cs_n = 1'b0;
      waitc(8);
      foreach (hdr[i]) xfer(hdr[i], r);
      for (int i = 0; i < nbits; i++) begin
         mosi = 1'b0;
         waitc(8);
         sck = 1'b1;
         waitc(8);
         sck = 1'b0;
      end
      waitc(8);
      cs_n = 1'b1;
      waitc(16);
   endtask

   task automatic wait_idle();
      logic [7:0] r;
      logic [7:0] s;
      do begin
         cs_n = 1'b0;
         waitc(8);
         xfer(8'h05, r);
         xfer(8'h00, s);
         waitc(8);
         cs_n = 1'b1;
         waitc(16);
      end while (s[0]);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (got_q.size() != 0) begin
            logic [7:0] g;
            logic [7:0] e;
            string t;
            g = got_q.pop_front();
            n_chk++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL unexpected byte actual=%02h expected=none", g);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (g !== e) begin
                  n_bad++;
                  $display("FAIL %s actual=%02h expected=%02h", t, g, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      waitc(5);
      n_chk++;
      if (miso !== 1'b0) begin
         n_bad++;
         $display("FAIL R3 reset miso actual=%b expected=0", miso);
      end
      rst_n = 1'b1;
      waitc(5);

      // R4 reset status, R13 erased array, R1 sequential read
      expect_b(8'h00, "R4 reset status");
      xact('{8'h05}, 1);
      expect_b(8'hFF, "R13 reset array byte 0");
      expect_b(8'hFF, "R13 reset array byte 1");
      xact('{8'h03, 8'h00, 8'h00, 8'h00}, 2);

      // R6 program without latch
      xact('{8'h02, 8'h00, 8'h00, 8'h10, 8'hA5}, 0);
      expect_b(8'hFF, "R6 program without latch ignored");
      xact('{8'h03, 8'h00, 8'h00, 8'h10}, 1);

      // R5 latch set and clear
      xact('{8'h06}, 0);
      expect_b(8'h02, "R5 latch set");
      xact('{8'h05}, 1);
      xact('{8'h04}, 0);
      expect_b(8'h00, "R5 latch cleared");
      xact('{8'h05}, 1);

      // R7 program, R9 busy status
      xact('{8'h06}, 0);
      xact('{8'h02, 8'h00, 8'h00, 8'h10, 8'hA5, 8'h3C}, 0);
      expect_b(8'h03, "R9 busy with latch");
      xact('{8'h05}, 1);
      wait_idle();
      expect_b(8'h00, "R9 latch cleared after program");
      xact('{8'h05}, 1);
      expect_b(8'hA5, "R7 programmed byte 0");
      expect_b(8'h3C, "R7 programmed byte 1");
      expect_b(8'hFF, "R1 next byte");
      xact('{8'h03, 8'h00, 8'h00, 8'h10}, 3);

      // R7 AND behaviour
      xact('{8'h06}, 0);
      xact('{8'h02, 8'h00, 8'h00, 8'h10, 8'h0F}, 0);
      wait_idle();
      expect_b(8'h05, "R7 program ANDs old and new");
      xact('{8'h03, 8'h00, 8'h00, 8'h10}, 1);

      // R7 page wrap in page 2 and page 0
      xact('{8'h06}, 0);
      xact('{8'h02, 8'h00, 8'h01, 8'h7E, 8'h11, 8'h22, 8'h33}, 0);
      wait_idle();
      expect_b(8'h11, "R7 wrap 0x17E");
      expect_b(8'h22, "R7 wrap 0x17F");
      expect_b(8'hFF, "R7 no spill to 0x180");
      xact('{8'h03, 8'h00, 8'h01, 8'h7E}, 3);
      expect_b(8'h33, "R7 wrapped byte at 0x100");
      xact('{8'h03, 8'h00, 8'h01, 8'h00}, 1);
      xact('{8'h06}, 0);
      xact('{8'h02, 8'h00, 8'h00, 8'h7F, 8'h99, 8'h77}, 0);
      wait_idle();
      xact('{8'h06}, 0);
      xact('{8'h02, 8'h00, 8'h03, 8'hFF, 8'h5A}, 0);
      wait_idle();

      // R2 array wrap, high address bits ignored
      expect_b(8'h5A, "R2 last byte");
      expect_b(8'h77, "R2 wrap to byte 0");
      expect_b(8'hFF, "R2 byte 1");
      xact('{8'h03, 8'h00, 8'h03, 8'hFF}, 3);
      expect_b(8'h5A, "R2 upper address bits ignored");
      xact('{8'h03, 8'h12, 8'h07, 8'hFF}, 1);

      // R10 partial program discarded, latch kept
      xact('{8'h06}, 0);
      xact_partial('{8'h02, 8'h00, 8'h02, 8'h00, 8'hA5}, 4);
      expect_b(8'h02, "R10 latch unchanged and idle");
      xact('{8'h05}, 1);
      expect_b(8'hFF, "R10 partial program discarded");
      xact('{8'h03, 8'h00, 8'h02, 8'h00}, 1);

      // R8 sector erase, R9 read rejected while busy
      xact('{8'hD8, 8'h00, 8'h00, 8'h40}, 0);
      expect_b(8'h00, "R9 read ignored while busy");
      xact('{8'h03, 8'h00, 8'h01, 8'h00}, 1);
      wait_idle();
      expect_b(8'hFF, "R8 sector byte 0x010 erased");
      xact('{8'h03, 8'h00, 8'h00, 8'h10}, 1);
      expect_b(8'hFF, "R8 sector byte 0x0FF erased");
      expect_b(8'h33, "R8 next sector untouched");
      xact('{8'h03, 8'h00, 8'h00, 8'hFF}, 2);

      // R8 bulk erase
      xact('{8'h06}, 0);
      xact('{8'hC7}, 0);
      wait_idle();
      expect_b(8'hFF, "R8 bulk erase 0x100");
      xact('{8'h03, 8'h00, 8'h01, 8'h00}, 1);
      expect_b(8'hFF, "R8 bulk erase 0x3FF");
      xact('{8'h03, 8'h00, 8'h03, 8'hFF}, 1);

      // R11 power-down and release
      xact('{8'h06}, 0);
      xact('{8'hB9}, 0);
      expect_b(8'h00, "R11 status ignored in power-down");
      xact('{8'h05}, 1);
      expect_b(8'h00, "R11 read ignored in power-down");
      xact('{8'h03, 8'h00, 8'h00, 8'h00}, 1);
      expect_b(8'h10, "R11 signature byte");
      expect_b(8'h10, "R11 signature repeats");
      xact('{8'hAB, 8'h00, 8'h00, 8'h00}, 2);
      expect_b(8'h02, "R11 status after release");
      xact('{8'h05}, 1);

      // R12 status write
      xact('{8'h01, 8'hFF}, 0);
      expect_b(8'hFF, "R12 stored bits while busy");
      xact('{8'h05}, 1);
      wait_idle();
      expect_b(8'hFC, "R12 stored bits after completion");
      xact('{8'h05}, 1);
      xact('{8'h01, 8'h00}, 0);
      expect_b(8'hFC, "R6 status write without latch ignored");
      xact('{8'h05}, 1);

      waitc(20);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard actual=%0d left expected=0", exp_q.size());
      end
      n_chk++;
      if (miso !== 1'b0) begin
         n_bad++;
         $display("FAIL R3 idle miso actual=%b expected=0", miso);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule